// File: doc/BRIEF.md
# Double-Precision Ordered Compare with Condition Flags

This block compares two packed 64-bit binary floating-point values and reports the result as a four-bit condition code in negative/zero/carry/overflow form, together with an invalid-operation indication. It works on the raw encodings and never unpacks them into an arithmetic form. The order comes from the sign bits and from the magnitude bits read as an unsigned integer. A core's floating-point unit uses it to set the condition flags for a later conditional branch or select.

Two control inputs shape each compare. The first selects whether a quiet NaN raises invalid, as a signalling NaN always does. The second replaces the second operand with positive zero, so that one encoder serves both the compare-with-zero form and the two-operand form. A parameter chooses a registered output, with a latency of one cycle, or a purely combinational path.

Top module: `fp64_cmp_flags`

## Requirements
- R1: An operand whose 11-bit exponent field is all ones and whose 52-bit fraction is nonzero is a NaN. If either operand is a NaN, the code is unordered, 4'b0011 (C and V).
- R2: Invalid is raised for each NaN operand whose fraction MSB (bit 51) is 0, in either mode. When `qnan_signal_i` is 1, a NaN whose bit 51 is 1 also raises invalid. When `qnan_signal_i` is 0, such a NaN does not.
- R3: When neither operand is a NaN, invalid is 0.
- R4: Two non-NaN operands with identical bit patterns give the equal code, 4'b0110 (Z and C).
- R5: +0 and -0 compare equal to each other in every pairing.
- R6: When the signs differ and the operands are not both zero, the negative one is the lesser.
- R7: When the signs match, the larger magnitude is greater for positive values and lesser for negative values. The code for less is 4'b1000 (N only) and the code for greater is 4'b0010 (C only).
- R8: Infinities are ordered values. +inf is above every finite value, -inf is below every finite value, and an infinity equals the infinity of the same sign.
- R9: While `zero_cmp_i` is 1, `b_i` has no effect and the first operand is compared with +0.
- R10: With the default registered output, the code and invalid for the inputs present at a rising clock edge appear after that edge. While reset is asserted, both outputs are cleared to zero.
- R11: Out of reset, the code is always exactly one of 4'b1000, 4'b0110, 4'b0010 or 4'b0011. Bit order is {N,Z,C,V}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 64 | First operand, packed double |
| b_i | input | 64 | Second operand, packed double |
| qnan_signal_i | input | 1 | 1: quiet NaNs also raise invalid |
| zero_cmp_i | input | 1 | 1: compare `a_i` with +0 and ignore `b_i` |
| nzcv_o | output | 4 | Condition code {N,Z,C,V} |
| invalid_o | output | 1 | Invalid-operation indication |

## Verification
The case hardest to reach from the ports is a NaN kind that the compare-with-zero selection hides: a signalling NaN on `b_i` while `zero_cmp_i` is 1 must not raise invalid, and it must not force the unordered code. Mixed NaN pairs are also hard to reach, where one operand is quiet, the other is signalling, and the mode input decides the outcome. The stimulus sweeps every ordered pair of sixteen representative encodings. These are both zeros, the smallest subnormals, ones, values with a set fraction, the largest finite values, infinities, and quiet and signalling NaNs of both signs. Each pair is run under all four settings of the two control inputs, so every one of those combinations is driven.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    // Condition code, bit order {N,Z,C,V}
    typedef enum logic [3:0] {
        CMP_LT = 4'b1000,
        CMP_EQ = 4'b0110,
        CMP_GT = 4'b0010,
        CMP_UN = 4'b0011
    } cmp_code_e;

    // Per-operand classification used by the ordering stage
    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_quiet;
        logic is_zero;
    } op_class_t;

    // A NaN operand raises invalid when it signals, or when quiet NaNs are made to signal
    function automatic logic nan_raises(op_class_t cls, logic qsig);
        return cls.is_nan && (qsig || !cls.is_quiet);
    endfunction

    // Ordered outcome from sign relation and magnitude relation
    function automatic cmp_code_e ordered_code(logic eq, logic a_neg, logic signs_differ,
                                               logic mag_lt);
        if (eq)
            return CMP_EQ;
        else if (signs_differ)
            return a_neg ? CMP_LT : CMP_GT;
        else
            return (a_neg ^ mag_lt) ? CMP_LT : CMP_GT;
    endfunction

endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0]   val_i,
    output op_class_t               cls_o,
    output logic [EXP_W+FRAC_W-1:0] mag_o
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int MAG_W = W - 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = val_i[MAG_W-1 -: EXP_W];
    assign frac_f = val_i[FRAC_W-1:0];

    always_comb begin
        cls_o.sign     = val_i[W-1];
        cls_o.is_nan   = (&exp_f) && (|frac_f);
        cls_o.is_quiet = frac_f[FRAC_W-1];
        cls_o.is_zero  = ~|val_i[MAG_W-1:0];
    end

    assign mag_o = val_i[MAG_W-1:0];

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int MAG_W = 63
) (
    input  op_class_t        cls_a_i,
    input  op_class_t        cls_b_i,
    input  logic [MAG_W-1:0] mag_a_i,
    input  logic [MAG_W-1:0] mag_b_i,
    input  logic             qsig_i,
    output cmp_code_e        code_o,
    output logic             invalid_o
);
    logic unordered;
    logic same_bits;
    logic both_zero;
    logic signs_differ;
    logic mag_lt;

    assign unordered    = cls_a_i.is_nan || cls_b_i.is_nan;
    assign signs_differ = cls_a_i.sign ^ cls_b_i.sign;
    assign same_bits    = !signs_differ && (mag_a_i == mag_b_i);
    assign both_zero    = cls_a_i.is_zero && cls_b_i.is_zero;
    assign mag_lt       = mag_a_i < mag_b_i;

    always_comb begin
        if (unordered)
            code_o = CMP_UN;
        else
            code_o = ordered_code(same_bits || both_zero, cls_a_i.sign, signs_differ, mag_lt);
    end

    assign invalid_o = nan_raises(cls_a_i, qsig_i) || nan_raises(cls_b_i, qsig_i);

endmodule

// File: rtl/fpcmp_outstage.sv
module fpcmp_outstage
    import fpcmp_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  cmp_code_e code_i,
    input  logic      invalid_i,
    output logic [3:0] nzcv_o,
    output logic      invalid_o
);
    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    nzcv_o    <= 4'b0000;
                    invalid_o <= 1'b0;
                end else begin
                    nzcv_o    <= code_i;
                    invalid_o <= invalid_i;
                end
            end
        end else begin : g_comb
            assign nzcv_o    = code_i;
            assign invalid_o = invalid_i;
        end
    endgenerate

endmodule

// File: rtl/fp64_cmp_flags.sv
module fp64_cmp_flags
    import fpcmp_pkg::*;
#(
    parameter int EXP_W   = 11,
    parameter int FRAC_W  = 52,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [EXP_W+FRAC_W:0]   a_i,
    input  logic [EXP_W+FRAC_W:0]   b_i,
    input  logic                    qnan_signal_i,
    input  logic                    zero_cmp_i,
    output logic [3:0]              nzcv_o,
    output logic                    invalid_o
);
    localparam int W     = 1 + EXP_W + FRAC_W;
    localparam int MAG_W = W - 1;

    logic [W-1:0]     b_eff;
    op_class_t        cls_a, cls_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    cmp_code_e        code;
    logic             invalid;

    // Compare-with-zero substitutes positive zero for the second operand
    assign b_eff = zero_cmp_i ? '0 : b_i;

    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
        .val_i (a_i),
        .cls_o (cls_a),
        .mag_o (mag_a)
    );

    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
        .val_i (b_eff),
        .cls_o (cls_b),
        .mag_o (mag_b)
    );

    fpcmp_order #(.MAG_W(MAG_W)) u_order (
        .cls_a_i   (cls_a),
        .cls_b_i   (cls_b),
        .mag_a_i   (mag_a),
        .mag_b_i   (mag_b),
        .qsig_i    (qnan_signal_i),
        .code_o    (code),
        .invalid_o (invalid)
    );

    fpcmp_outstage #(.OUT_REG(OUT_REG)) u_out (
        .clk       (clk),
        .rst       (rst),
        .code_i    (code),
        .invalid_i (invalid),
        .nzcv_o    (nzcv_o),
        .invalid_o (invalid_o)
    );

endmodule

// File: rtl/fpcmp_checker.sv
module fpcmp_checker #(
    parameter int EXP_W   = 11,
    parameter int FRAC_W  = 52,
    parameter bit OUT_REG = 1'b1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [EXP_W+FRAC_W:0] a_i,
    input logic [EXP_W+FRAC_W:0] b_i,
    input logic                  qnan_signal_i,
    input logic                  zero_cmp_i,
    input logic [3:0]            nzcv_o,
    input logic                  invalid_o
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic         primed;
    logic [W-1:0] d_a, d_b;
    logic         d_qsig, d_zero;
    logic         d_a_nan, d_a_zero;

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    // Inputs aligned with the outputs they produced
    generate
        if (OUT_REG) begin : g_dly
            always_ff @(posedge clk) begin
                d_a    <= a_i;
                d_b    <= b_i;
                d_qsig <= qnan_signal_i;
                d_zero <= zero_cmp_i;
            end
        end else begin : g_now
            assign d_a    = a_i;
            assign d_b    = b_i;
            assign d_qsig = qnan_signal_i;
            assign d_zero = zero_cmp_i;
        end
    endgenerate

    assign d_a_nan  = (&d_a[W-2 -: EXP_W]) && (|d_a[FRAC_W-1:0]);
    assign d_a_zero = ~|d_a[W-2:0];

    // R11
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        primed |-> (nzcv_o == 4'b1000 || nzcv_o == 4'b0110 ||
                    nzcv_o == 4'b0010 || nzcv_o == 4'b0011));

    // R3
    invalid_only_unordered_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && invalid_o) |-> (nzcv_o == 4'b0011));

    // R2
    quiet_mode_signals_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && d_qsig && d_a_nan) |-> invalid_o);

    // R9
    zero_vs_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && d_zero && d_a_zero) |-> (nzcv_o == 4'b0110));

    // R4
    self_equal_chk: assert property (@(posedge clk) disable iff (rst)
        (primed && !d_zero && (d_a == d_b) && !d_a_nan) |-> (nzcv_o == 4'b0110));

    generate
        if (OUT_REG) begin : g_rst_chk
            // R10
            reset_clears_chk: assert property (@(posedge clk)
                rst |=> (nzcv_o == 4'b0000 && !invalid_o));
        end
    endgenerate

endmodule

bind fp64_cmp_flags fpcmp_checker #(
    .EXP_W   (EXP_W),
    .FRAC_W  (FRAC_W),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .a_i           (a_i),
    .b_i           (b_i),
    .qnan_signal_i (qnan_signal_i),
    .zero_cmp_i    (zero_cmp_i),
    .nzcv_o        (nzcv_o),
    .invalid_o     (invalid_o)
);

// File: tb/fp64_cmp_flags_test.sv
module fp64_cmp_flags_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic        qnan_signal_i = 1'b0;
    logic        zero_cmp_i = 1'b0;
    logic [3:0]  nzcv_o;
    logic        invalid_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    fp64_cmp_flags uut (
        .clk           (clk),
        .rst           (rst),
        .a_i           (a_i),
        .b_i           (b_i),
        .qnan_signal_i (qnan_signal_i),
        .zero_cmp_i    (zero_cmp_i),
        .nzcv_o        (nzcv_o),
        .invalid_o     (invalid_o)
    );

    function automatic logic [63:0] sample_val(int i);
        case (i)
            0:  return 64'h0000_0000_0000_0000; // +0
            1:  return 64'h8000_0000_0000_0000; // -0
            2:  return 64'h0000_0000_0000_0001; // +min subnormal
            3:  return 64'h8000_0000_0000_0001; // -min subnormal
            4:  return 64'h3FF0_0000_0000_0000; // +1
            5:  return 64'hBFF0_0000_0000_0000; // -1
            6:  return 64'h3FF8_0000_0000_0000; // +1.5
            7:  return 64'hBFF8_0000_0000_0000; // -1.5
            8:  return 64'h7FEF_FFFF_FFFF_FFFF; // +max
            9:  return 64'hFFEF_FFFF_FFFF_FFFF; // -max
            10: return 64'h7FF0_0000_0000_0000; // +inf
            11: return 64'hFFF0_0000_0000_0000; // -inf
            12: return 64'h7FF8_0000_0000_0000; // quiet NaN
            13: return 64'hFFF8_0000_0000_0001; // quiet NaN, negative
            14: return 64'h7FF0_0000_0000_0001; // signalling NaN
            default: return 64'hFFF4_0000_0000_0000; // signalling NaN, negative
        endcase
    endfunction

    function automatic logic is_nan(logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 52'd0);
    endfunction

    function automatic logic is_inf(logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] == 52'd0);
    endfunction

    // Signed integer key that orders non-NaN encodings numerically
    function automatic logic signed [64:0] order_key(logic [63:0] v);
        logic signed [64:0] m;
        m = $signed({2'b00, v[62:0]});
        return v[63] ? -m : m;
    endfunction

    function automatic logic [3:0] exp_code(logic [63:0] a, logic [63:0] b);
        if (is_nan(a) || is_nan(b)) return 4'b0011;
        if (order_key(a) == order_key(b)) return 4'b0110;
        if (order_key(a) < order_key(b)) return 4'b1000;
        return 4'b0010;
    endfunction

    function automatic logic exp_inv(logic [63:0] a, logic [63:0] b, logic qs);
        return (is_nan(a) && (qs || !a[51])) || (is_nan(b) && (qs || !b[51]));
    endfunction

    task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b exp=%b a=%h b=%h qs=%b zc=%b",
                     tag, got, exp, a_i, b_i, qnan_signal_i, zero_cmp_i);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog got=%0d exp=<150000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [63:0] beff;
        string       ctag, itag;

        // R10: reset clears the outputs
        repeat (3) @(posedge clk);
        @(negedge clk);
        a_i = sample_val(14);
        b_i = sample_val(4);
        check("R10 reset code", nzcv_o, 4'b0000);
        check("R10 reset invalid", {3'b000, invalid_o}, 4'b0000);
        rst = 1'b0;

        // R10: one-cycle latency
        a_i = sample_val(4); b_i = sample_val(4);
        @(negedge clk);
        check("R4 equal after latency", nzcv_o, 4'b0110);
        a_i = sample_val(5); b_i = sample_val(4);
        #1;
        check("R10 output holds before edge", nzcv_o, 4'b0110);
        @(negedge clk);
        check("R10 output updates after edge", nzcv_o, 4'b1000);

        // Directed corner cases
        a_i = sample_val(1); b_i = sample_val(0);
        @(negedge clk);
        check("R5 -0 vs +0", nzcv_o, 4'b0110);
        a_i = sample_val(10); b_i = sample_val(8);
        @(negedge clk);
        check("R8 +inf above max", nzcv_o, 4'b0010);
        a_i = sample_val(9); b_i = sample_val(7);
        @(negedge clk);
        check("R7 negative larger magnitude is less", nzcv_o, 4'b1000);
        a_i = sample_val(12); b_i = sample_val(4); qnan_signal_i = 1'b0;
        @(negedge clk);
        check("R2 quiet NaN no signal mode", {3'b000, invalid_o}, 4'b0000);
        a_i = sample_val(4); b_i = sample_val(14); zero_cmp_i = 1'b1;
        @(negedge clk);
        check("R9 signalling b ignored code", nzcv_o, 4'b0010);
        check("R9 signalling b ignored invalid", {3'b000, invalid_o}, 4'b0000);
        zero_cmp_i = 1'b0;

        // Sweep every pair under every mode setting
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    a_i = sample_val(i);
                    b_i = sample_val(j);
                    qnan_signal_i = m[0];
                    zero_cmp_i    = m[1];
                    @(negedge clk);
                    beff = zero_cmp_i ? 64'd0 : b_i;
                    if (zero_cmp_i) ctag = "R9";
                    else if (is_nan(a_i) || is_nan(beff)) ctag = "R1";
                    else if (is_inf(a_i) || is_inf(beff)) ctag = "R8";
                    else if (a_i[62:0] == 63'd0 && beff[62:0] == 63'd0) ctag = "R5";
                    else if (a_i == beff) ctag = "R4";
                    else if (a_i[63] != beff[63]) ctag = "R6";
                    else ctag = "R7";
                    itag = (is_nan(a_i) || is_nan(beff)) ? "R2 invalid" : "R3 invalid";
                    check(ctag, nzcv_o, exp_code(a_i, beff));
                    check(itag, {3'b000, invalid_o},
                          {3'b000, exp_inv(a_i, beff, qnan_signal_i)});
                    check("R11 legal code",
                          {3'b000, (nzcv_o == 4'b1000 || nzcv_o == 4'b0110 ||
                                    nzcv_o == 4'b0010 || nzcv_o == 4'b0011)},
                          4'b0001);
                end
            end
        end

        finish_run();
    end

endmodule